// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the timing strobes for a UART from the module clock. It emits a 16x oversampling enable (`sample_en`) for the receiver and transmitter sampling logic, and a bit-rate enable (`bit_en`) that fires once for every sixteen sample enables. The divisor has two parts. The integer part is 13 bits. The fractional part is 5 bits, counted in thirty-seconds of one divisor count. The resulting rate is clk / (16 * (SBR + BRFA/32)).

Software reaches the divisor through byte-wide register writes. The integer divisor is split across a high byte and a low byte. Writing the high byte only stages its bits. Writing the low byte loads the whole 13-bit divisor in one step and restarts the timing chain, so the chain never runs on a half-updated divisor.

The fraction is applied within each window of 32 consecutive sample periods. Exactly BRFA of those periods last one module clock longer, and the long periods are spread as evenly as the count allows. A `restart` input lets the receiver realign the bit-rate phase to a detected start edge.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `sample_en`, `bit_en` and `aux_en` are 0, and the integer divisor is 0, so the generator is stopped.
- R2: A write with `reg_sel` = 2'b00 (high byte) stores `reg_wdata[4:0]` as staged upper divisor bits. It does not change the running rate until a low-byte write follows.
- R3: A write with `reg_sel` = 2'b01 (low byte) loads the divisor as {staged[4:0], `reg_wdata`[7:0]} in a single clock. The same write clears the period, window and bit-phase counters.
- R4: A high-byte write stores `reg_wdata[7:5]` on `aux_en`. Low-byte, fraction and `reg_sel` = 2'b11 writes leave `aux_en` unchanged.
- R5: A write with `reg_sel` = 2'b10 sets the fraction to `reg_wdata[4:0]`. Bits [7:5] of that write are ignored.
- R6: While the integer divisor is 0, neither `sample_en` nor `bit_en` is ever asserted.
- R7: Sample periods are numbered w = 0..31 within each window. Period w lasts SBR + 1 clocks when floor((w+1)*BRFA/32) > floor(w*BRFA/32), and SBR clocks otherwise. Each window therefore totals 32*SBR + BRFA clocks.
- R8: With SBR = 1 and BRFA = 0, `sample_en` is high on every clock. This is the highest rate, clk/16 bits per second.
- R9: `bit_en` is a one-clock pulse that coincides with every 16th `sample_en`, counted from the last restart or low-byte write.
- R10: `restart` clears the period, window and bit-phase counters. Both enables are low in the clock after it. The next `sample_en` comes one full period later, and the next `bit_en` comes 16 periods later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one clock per write |
| reg_sel | input | 2 | Target register: 00 high byte, 01 low byte, 10 fraction, 11 none |
| reg_wdata | input | 8 | Write data |
| restart | input | 1 | Realign the period, window and bit phase |
| sample_en | output | 1 | 16x oversampling enable |
| bit_en | output | 1 | Bit-rate enable, on the 16th sample enable |
| aux_en | output | 3 | Unrelated enable bits held in the high byte [7:5] |

## Verification
The hardest case to reach is the placement of the stretched periods inside a 32-period window. That placement shows only as a one-clock shift between sample enables. It also depends on where the window starts, which is fixed only by the last restart or low-byte write. The stimulus loads divisors last, so the load itself realigns the window. It then runs several fractions (0, 8, 31), and the behavioural model compares every clock against the floor-difference rule. Counting sample enables over exactly 32*SBR + BRFA clocks, and over one clock fewer, pins the window total.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic [1:0] {
    SEL_HIGH = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_FRAC = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5,
  localparam int HI_W  = DIV_W - BYTE_W,
  localparam int AUX_W = BYTE_W - HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [DIV_W-1:0]  sbr_q,
  output logic [HI_W-1:0]   hi_stage_q,
  output logic [FRAC_W-1:0] brfa_q,
  output logic [AUX_W-1:0]  aux_q,
  output logic              load_pulse
);
  import baud_pkg::*;

  logic wr_hi, wr_lo, wr_frac;
  assign wr_hi      = reg_wr && (reg_sel == SEL_HIGH);
  assign wr_lo      = reg_wr && (reg_sel == SEL_LOW);
  assign wr_frac    = reg_wr && (reg_sel == SEL_FRAC);
  assign load_pulse = wr_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sbr_q      <= '0;
      hi_stage_q <= '0;
      brfa_q     <= '0;
      aux_q      <= '0;
    end else begin
      if (wr_hi) begin
        hi_stage_q <= reg_wdata[HI_W-1:0];
        aux_q      <= reg_wdata[BYTE_W-1:HI_W];
      end
      if (wr_lo)   sbr_q  <= {hi_stage_q, reg_wdata};
      if (wr_frac) brfa_q <= reg_wdata[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/baud_stretch.sv
module baud_stretch #(
  parameter int FRAC_W = 5,
  localparam int PROD_W = 2 * FRAC_W + 1
) (
  input  logic [FRAC_W-1:0] win_idx,
  input  logic [FRAC_W-1:0] brfa,
  output logic              stretch
);
  logic [PROD_W-1:0] cur_p, nxt_p;

  always_comb begin
    cur_p   = PROD_W'(win_idx) * PROD_W'(brfa);
    nxt_p   = cur_p + PROD_W'(brfa);
    stretch = (nxt_p >> FRAC_W) != (cur_p >> FRAC_W);
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5,
  parameter int OSR    = 16,
  localparam int CNT_W = DIV_W + 1,
  localparam int PH_W  = $clog2(OSR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [DIV_W-1:0]  sbr,
  input  logic [FRAC_W-1:0] brfa,
  output logic              tick_q,
  output logic              bit_q
);
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] win_q;
  logic [PH_W-1:0]   phase_q;
  logic              stretch;
  logic [CNT_W-1:0]  last_cnt;

  baud_stretch #(.FRAC_W(FRAC_W)) u_stretch (
    .win_idx (win_q),
    .brfa    (brfa),
    .stretch (stretch)
  );

  assign last_cnt = CNT_W'(sbr) + CNT_W'(stretch) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || (sbr == '0)) begin
      cnt_q   <= '0;
      win_q   <= '0;
      phase_q <= '0;
      tick_q  <= 1'b0;
      bit_q   <= 1'b0;
    end else if (cnt_q >= last_cnt) begin
      cnt_q   <= '0;
      win_q   <= win_q + 1'b1;
      phase_q <= (phase_q == PH_W'(OSR - 1)) ? '0 : phase_q + 1'b1;
      tick_q  <= 1'b1;
      bit_q   <= (phase_q == PH_W'(OSR - 1));
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
      bit_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 13,
  parameter int FRAC_W = 5,
  parameter int OSR    = 16,
  localparam int HI_W  = DIV_W - BYTE_W,
  localparam int AUX_W = BYTE_W - HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              restart,
  output logic              sample_en,
  output logic              bit_en,
  output logic [AUX_W-1:0]  aux_en
);
  logic [DIV_W-1:0]  sbr_q;
  logic [HI_W-1:0]   hi_stage_q;
  logic [FRAC_W-1:0] brfa_q;
  logic              load_pulse;

  baud_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .sbr_q      (sbr_q),
    .hi_stage_q (hi_stage_q),
    .brfa_q     (brfa_q),
    .aux_q      (aux_en),
    .load_pulse (load_pulse)
  );

  baud_divider #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .OSR(OSR)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (restart || load_pulse),
    .sbr    (sbr_q),
    .brfa   (brfa_q),
    .tick_q (sample_en),
    .bit_q  (bit_en)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 13,
  localparam int HI_W  = DIV_W - BYTE_W,
  localparam int AUX_W = BYTE_W - HI_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              restart,
  input logic              sample_en,
  input logic              bit_en,
  input logic [AUX_W-1:0]  aux_en,
  input logic [DIV_W-1:0]  sbr_q,
  input logic [HI_W-1:0]   hi_stage_q
);
  // R9
  bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> sample_en);

  // R10
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!sample_en && !bit_en));

  // R3
  atomic_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'b01) |=> (sbr_q == {$past(hi_stage_q), $past(reg_wdata)}));

  // R4
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel != 2'b00) |=> $stable(aux_en));

  // R6
  stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sbr_q == '0) |-> (!sample_en && !bit_en));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .restart    (restart),
  .sample_en  (sample_en),
  .bit_en     (bit_en),
  .aux_en     (aux_en),
  .sbr_q      (sbr_q),
  .hi_stage_q (hi_stage_q)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'b00;
  logic [7:0] reg_wdata = 8'h00;
  logic       restart = 1'b0;
  logic       sample_en, bit_en;
  logic [2:0] aux_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .restart(restart), .sample_en(sample_en),
    .bit_en(bit_en), .aux_en(aux_en)
  );

  // behavioural model state
  int m_sbr, m_hi, m_aux, m_brfa, m_el, m_w, m_n;
  bit m_se, m_be;

  always @(posedge clk) begin
    int need;
    if (!rst_n) begin
      m_sbr = 0; m_hi = 0; m_aux = 0; m_brfa = 0;
      m_el = 0; m_w = 0; m_n = 0; m_se = 0; m_be = 0;
    end else begin
      if (restart || (reg_wr && reg_sel == 2'b01) || m_sbr == 0) begin
        m_el = 0; m_w = 0; m_n = 0; m_se = 0; m_be = 0;
      end else begin
        need = m_sbr + ((m_w + 1) * m_brfa) / 32 - (m_w * m_brfa) / 32;
        m_el = m_el + 1;
        if (m_el >= need) begin
          m_el = 0;
          m_se = 1;
          m_w  = (m_w + 1) % 32;
          m_n  = (m_n + 1) % 16;
          m_be = (m_n == 0);
        end else begin
          m_se = 0; m_be = 0;
        end
      end
      if (reg_wr) begin
        case (reg_sel)
          2'b00: begin m_hi = reg_wdata & 31; m_aux = reg_wdata >> 5; end
          2'b01: m_sbr = m_hi * 256 + reg_wdata;
          2'b10: m_brfa = reg_wdata & 31;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sample_en == m_se, "R7 sample_en vs model", sample_en, m_se);
      chk(bit_en == m_be, "R9 bit_en vs model", bit_en, m_be);
      chk(aux_en == m_aux[2:0], "R4 aux_en vs model", aux_en, m_aux);
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic count(input int n, output int se_n, output int be_n);
    se_n = 0; be_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      se_n += int'(sample_en);
      be_n += int'(bit_en);
    end
  endtask

  initial begin
    int s, b;
    repeat (3) @(negedge clk);
    // R1
    chk(sample_en == 0 && bit_en == 0, "R1 enables after reset", sample_en, 0);
    chk(aux_en == 0, "R1 aux after reset", aux_en, 0);
    rst_n = 1'b1;
    count(50, s, b);
    chk(s == 0, "R1 stopped after reset", s, 0);

    // SBR=3, BRFA=8, aux=5
    wr(2'b00, 8'hA0);
    chk(aux_en == 3'd5, "R4 aux from high byte", aux_en, 5);
    wr(2'b10, 8'hE8);
    wr(2'b01, 8'h03);
    chk(aux_en == 3'd5, "R4 aux kept over low write", aux_en, 5);
    count(103, s, b);
    chk(s == 31, "R7 ticks in 32*3+8-1 clocks", s, 31);
    count(1, s, b);
    chk(s == 1, "R7 32nd tick at window end", s, 1);
    count(104, s, b);
    chk(s == 32, "R5 fraction upper bits ignored", s, 32);
    wr(2'b11, 8'hFF);
    chk(aux_en == 3'd5, "R4 aux kept over unused select", aux_en, 5);

    // R2: high write alone leaves rate
    wr(2'b00, 8'h01);
    pulse_restart();
    count(208, s, b);
    chk(s == 64, "R2 staged high byte not applied", s, 64);
    chk(b == 4, "R9 bit enables per 64 ticks", b, 4);

    // R3: low write applies staged -> SBR=256, fraction 0
    wr(2'b10, 8'h00);
    wr(2'b01, 8'h00);
    count(512, s, b);
    chk(s == 2, "R3 atomic load 256", s, 2);

    // R8
    wr(2'b00, 8'h00);
    wr(2'b01, 8'h01);
    count(40, s, b);
    chk(s == 40, "R8 every clock at max rate", s, 40);

    // R7 with BRFA=31, SBR=2
    wr(2'b10, 8'h1F);
    wr(2'b01, 8'h02);
    count(94, s, b);
    chk(s == 31, "R7 brfa 31 window minus one", s, 31);
    count(1, s, b);
    chk(s == 1, "R7 brfa 31 window end", s, 1);

    // R10 with SBR=2, BRFA=0
    wr(2'b10, 8'h00);
    count(13, s, b);
    pulse_restart();
    chk(sample_en == 0 && bit_en == 0, "R10 quiet after restart", sample_en, 0);
    count(31, s, b);
    chk(b == 0 && s == 15, "R10 no bit before 16 ticks", b, 0);
    count(1, s, b);
    chk(b == 1 && s == 1, "R10 bit at 16th tick", b, 1);

    // R6
    wr(2'b01, 8'h00);
    count(200, s, b);
    chk(s == 0 && b == 0, "R6 zero divisor stops", s, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule